// File: doc/BRIEF.md
# Presettable Up/Down Counter with Cascade Carry

A synchronous binary counter that counts up or down, one step per enabled rising clock edge. It can be preset from a parallel data input and cleared at any moment by an asynchronous reset. Each bit is a toggle cell built on a D flip-flop. Counting up, a bit flips when every bit below it is 1. Counting down, a bit flips when every bit below it is 0. Bit 0 flips on every enabled edge.

A terminal flag marks the last state of the sequence in the current direction. A cascade carry output is derived from that flag and the clock. It idles high and drops only during the low half of the clock period in which the counter sits at its terminal state. Its rising edge therefore falls on the clock edge that leaves the terminal state, and a following stage can use that edge as its clock.

Top module: `updown_preset_counter`

## Requirements
- R1: While rst_ni is low, q_o is 0 at once, without waiting for a clock edge, whatever load_i and cnt_en_i are.
- R2: With load_i high, q_o takes data_i at the next rising clock edge, even when cnt_en_i is low.
- R3: When load_i and cnt_en_i are both high, the load wins and no counting step is applied.
- R4: With load_i low and cnt_en_i low, q_o holds its value across clock edges.
- R5: With up_i = 1, cnt_en_i = 1 and load_i = 0, q_o increases by one per rising edge, and all ones wraps to 0.
- R6: With up_i = 0, cnt_en_i = 1 and load_i = 0, q_o decreases by one per rising edge, and 0 wraps to all ones.
- R7: term_o is high exactly when up_i = 1 and q_o is all ones, or when up_i = 0 and q_o is 0. It follows changes of up_i without a clock edge.
- R8: rco_o is high throughout every clock-high half-period. It is low in a clock-low half-period exactly when term_o is high.
- R9: rco_o rises together with the rising clock edge that moves q_o out of its terminal state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous clear, active low |
| load_i | input | 1 | Synchronous parallel preset request |
| data_i | input | WIDTH | Preset value |
| cnt_en_i | input | 1 | Counting enable |
| up_i | input | 1 | Direction: 1 up, 0 down |
| q_o | output | WIDTH | Counter value |
| term_o | output | 1 | Terminal state flag for the current direction |
| rco_o | output | 1 | Cascade carry, NOT(term_o AND NOT clk_i) |

## Verification
The bench builds the counter with its default WIDTH of 4. With that width both wraps, 1111 to 0000 counting up and 0000 to 1111 counting down, are reached within a handful of cycles from a preset. The carry output is sampled in each clock half around a terminal state, and once more just after the edge that leaves it. The asynchronous clear is applied in the middle of a clock-high phase while a load is pending.

// File: rtl/udc_pkg.sv
package udc_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/udc_toggle_chain.sv
module udc_toggle_chain #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic             up_i,
  input  logic             cnt_en_i,
  output logic [WIDTH-1:0] flip_o
);
  import udc_pkg::*;

  logic [WIDTH:0] all_one;
  logic [WIDTH:0] all_zero;

  assign all_one[0]  = 1'b1;
  assign all_zero[0] = 1'b1;

  for (genvar n = 0; n < WIDTH; n++) begin : g_chain
    assign all_one[n+1]  = all_one[n] & q_i[n];
    assign all_zero[n+1] = all_zero[n] & ~q_i[n];
    assign flip_o[n] = cnt_en_i &
                       ((dir_e'(up_i) == DIR_UP) ? all_one[n] : all_zero[n]);
  end
endmodule

// File: rtl/udc_bit_cell.sv
module udc_bit_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic p_i,
  input  logic flip_i,
  output logic q_o
);
  logic d;

  // load has priority over the toggle path
  always_comb begin
    if (load_i) d = p_i;
    else        d = q_o ^ flip_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d;
  end
endmodule

// File: rtl/udc_terminal.sv
module udc_terminal #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic [WIDTH-1:0] q_i,
  input  logic             up_i,
  output logic             term_o,
  output logic             rco_o
);
  import udc_pkg::*;

  always_comb begin
    if (dir_e'(up_i) == DIR_UP) term_o = &q_i;
    else                        term_o = ~|q_i;
  end

  // low only in the clock-low half of a terminal period
  assign rco_o = ~(term_o & ~clk_i);
endmodule

// File: rtl/updown_preset_counter.sv
module updown_preset_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             cnt_en_i,
  input  logic             up_i,
  output logic [WIDTH-1:0] q_o,
  output logic             term_o,
  output logic             rco_o
);
  logic [WIDTH-1:0] flip;
  logic [WIDTH-1:0] q;

  udc_toggle_chain #(.WIDTH(WIDTH)) i_chain (
    .q_i      (q),
    .up_i     (up_i),
    .cnt_en_i (cnt_en_i),
    .flip_o   (flip)
  );

  for (genvar n = 0; n < WIDTH; n++) begin : g_bit
    udc_bit_cell i_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load_i),
      .p_i    (data_i[n]),
      .flip_i (flip[n]),
      .q_o    (q[n])
    );
  end

  udc_terminal #(.WIDTH(WIDTH)) i_term (
    .clk_i  (clk_i),
    .q_i    (q),
    .up_i   (up_i),
    .term_o (term_o),
    .rco_o  (rco_o)
  );

  assign q_o = q;
endmodule

// File: rtl/udc_checker.sv
module udc_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic [WIDTH-1:0] data_i,
  input logic             cnt_en_i,
  input logic             up_i,
  input logic [WIDTH-1:0] q_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> q_o == '0);

  assert_load_value_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(load_i)) |-> q_o == $past(data_i));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(load_i) && !$past(cnt_en_i)) |-> $stable(q_o));

  assert_count_up_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(load_i) && $past(cnt_en_i) && $past(up_i))
      |-> q_o == $past(q_o) + ONE);

  assert_count_down_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(load_i) && $past(cnt_en_i) && !$past(up_i))
      |-> q_o == $past(q_o) - ONE);
endmodule

bind updown_preset_counter udc_checker #(.WIDTH(WIDTH)) i_udc_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .load_i   (load_i),
  .data_i   (data_i),
  .cnt_en_i (cnt_en_i),
  .up_i     (up_i),
  .q_o      (q_o)
);

// File: tb/test_updown_preset_counter.sv
module test_updown_preset_counter;
  localparam int W = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         load_i;
  logic [W-1:0] data_i;
  logic         cnt_en_i;
  logic         up_i;
  logic [W-1:0] q_o;
  logic         term_o;
  logic         rco_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  updown_preset_counter #(.WIDTH(W)) i_updown_preset_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .data_i(data_i),
    .cnt_en_i(cnt_en_i), .up_i(up_i), .q_o(q_o), .term_o(term_o), .rco_o(rco_o)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  task automatic preset(int v);
    @(negedge clk_i);
    load_i = 1'b1; data_i = W'(v);
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; load_i = 1'b0; data_i = '0; cnt_en_i = 1'b0; up_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1 reset value", q_o, 0);
    chk("R7 no terminal after reset up", term_o, 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_load_hold();
    @(negedge clk_i);
    load_i = 1'b1; data_i = 4'd9; cnt_en_i = 1'b0;
    @(negedge clk_i);
    load_i = 1'b0;
    chk("R2 load with enable low", q_o, 9);
    for (int i = 0; i < 3; i++) begin
      data_i = 4'd3;
      @(negedge clk_i);
      chk("R4 hold", q_o, 9);
    end
  endtask

  task automatic t_count_up();
    int exp;
    up_i = 1'b1;
    preset(13);
    exp = 13;
    cnt_en_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      exp = (exp + 1) % 16;
      chk("R5 count up", q_o, exp);
      chk("R7 term up", term_o, exp == 15);
    end
    cnt_en_i = 1'b0;
  endtask

  task automatic t_count_down();
    int exp;
    up_i = 1'b0;
    @(negedge clk_i);
    load_i = 1'b1; data_i = 4'd2; cnt_en_i = 1'b1;
    @(negedge clk_i);
    load_i = 1'b0;
    chk("R3 load over count", q_o, 2);
    exp = 2;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      exp = (exp + 15) % 16;
      chk("R6 count down", q_o, exp);
      chk("R7 term down", term_o, exp == 0);
    end
    cnt_en_i = 1'b0;
    preset(0);
    chk("R7 zero down is terminal", term_o, 1);
    up_i = 1'b1;
    #1;
    chk("R7 direction flip clears terminal", term_o, 0);
  endtask

  task automatic t_rco();
    up_i = 1'b1; cnt_en_i = 1'b1;
    @(negedge clk_i);
    load_i = 1'b1; data_i = 4'd14;
    @(posedge clk_i); #5;
    chk("R8 rco high half q=14", rco_o, 1);
    @(negedge clk_i);
    load_i = 1'b0;
    #5;
    chk("R8 rco low half non-terminal", rco_o, 1);
    @(posedge clk_i); #5;
    chk("R7 term at 15", term_o, 1);
    chk("R8 rco high in first half of terminal", rco_o, 1);
    @(negedge clk_i); #5;
    chk("R8 rco low in second half of terminal", rco_o, 0);
    @(posedge clk_i); #1;
    chk("R9 rco back high at leaving edge", rco_o, 1);
    chk("R9 q wrapped at that edge", q_o, 0);
    cnt_en_i = 1'b0;
  endtask

  task automatic t_async_reset();
    preset(6);
    cnt_en_i = 1'b1; up_i = 1'b1;
    @(posedge clk_i); #5;
    load_i = 1'b1; data_i = 4'd11;
    rst_ni = 1'b0;
    #1;
    chk("R1 async clear mid phase", q_o, 0);
    @(posedge clk_i); #5;
    chk("R1 reset overrides load and count", q_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1; load_i = 1'b0; cnt_en_i = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    t_load_hold();
    t_count_up();
    t_count_down();
    t_rco();
    t_async_reset();
    repeat (2) @(negedge clk_i);
    summary();
  end
endmodule